// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the transfer counter of one DMA channel. It holds a current address and a current count. From these and an 8-bit page value it forms the 24-bit physical byte address of every transfer. A register file outside the block supplies the base address, the base count, the page value and two mode bits: auto-initialise and decrement. A parameter builds the channel either as a byte channel or as a word channel. In a word channel the 16-bit counter holds a word address and the count is in 2-byte words.

A load strobe copies the base values into the current registers. Each transfer strobe issued while the channel is unmasked does two things. It presents the address on the bus output in the same cycle, and it advances the counters at the following clock edge. A transfer made while the count is zero raises terminal count. At that point the channel either reloads its base values (auto-initialise) or masks itself and stops. The page value is never incremented, so a run of transfers wraps inside a 64 KB region (byte channel) or a 128 KB region (word channel).

Top module: `dma_addr_engine`

## Requirements
- R1: After reset the channel is masked, the current count is 0 and the current address is 0.
- R2: With load_i high, the current address and count take base_addr_i and base_count_i at the next clock edge. cur_count_o shows the current count.
- R3: In a byte channel, bus_addr_o = {4'b0, page_i[3:0], current address}, so every address lies below 1 MB.
- R4: In a word channel, bus_addr_o = {page_i[7:1], current address, 1'b0}, so bit 0 is always 0.
- R5: With decrement_i low, each accepted transfer adds 1 to the current address. The address goes from 16'hFFFF to 16'h0000 and the page bits of bus_addr_o do not change.
- R6: With decrement_i high, each accepted transfer subtracts 1 from the current address, and the address goes from 16'h0000 to 16'hFFFF.
- R7: Each accepted transfer decrements the count. tc_o is high, in the same cycle, on the accepted transfer made while the count is 0. A programmed count of N-1 therefore gives N transfers.
- R8: With auto_init_i low, the terminal-count transfer sets the mask and wraps the count to 16'hFFFF. Later transfer strobes leave the count and address unchanged.
- R9: With auto_init_i high, the terminal-count transfer reloads the address and count from the base inputs and the channel stays unmasked.
- R10: A transfer strobe is ignored while masked_o is 1. mask_set_i sets the mask, mask_clr_i clears it, and mask_set_i wins when both are high.
- R11: remain_o is count+1 for a byte channel and 2*(count+1) for a word channel.
- R12: When load_i and xfer_i are high in the same cycle, the load wins: no terminal count is raised and the counters take the base values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_addr_i | input | 16 | Base address from the register file |
| base_count_i | input | 16 | Base count (transfers minus one) |
| page_i | input | 8 | Page value above the counter |
| auto_init_i | input | 1 | Reload at terminal count instead of stopping |
| decrement_i | input | 1 | Step the address down instead of up |
| load_i | input | 1 | Copy base values into the current registers |
| xfer_i | input | 1 | Transfer strobe |
| mask_set_i | input | 1 | Set the channel mask |
| mask_clr_i | input | 1 | Clear the channel mask |
| bus_addr_o | output | 24 | Physical byte address of the present transfer |
| tc_o | output | 1 | Terminal count, high during the last transfer |
| masked_o | output | 1 | Channel mask state |
| cur_count_o | output | 16 | Current count |
| remain_o | output | 18 | Bytes left to transfer |

## Verification
Some properties are checked on every cycle. Terminal count only fires on an unmasked channel whose count is zero. A masked channel keeps its count. A load, or an auto-initialise terminal count, leaves the base count in place. A stopping terminal count sets the mask. The counter field of the address moves by exactly one in the chosen direction. The unused high or low address bits stay zero. The bench scenarios show the exact address formats with real page values, the 64 KB wrap without a page carry, the N-transfer length, the remaining-byte figures for both channel widths, and how load and mask priorities resolve under random mixes of strobes.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef struct packed {
    logic auto_init;
    logic down;
  } xfer_mode_t;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              step_i,
  input  logic              down_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (reload_i) addr_q <= base_i;
    else if (step_i)   addr_q <= down_i ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              zero_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (reload_i) cnt_q <= base_i;
    else if (step_i)   cnt_q <= cnt_q - 1'b1; // 0 wraps to all-ones
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int BYTE_PAGE_W = 4,
  parameter bit WORD_CH     = 1'b0,
  localparam int BUS_W      = PAGE_W + ADDR_W,
  localparam int REM_W      = ADDR_W + 2
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cnt_i,
  output logic [BUS_W-1:0]  bus_addr_o,
  output logic [REM_W-1:0]  remain_o
);
  localparam int PAD_W = BUS_W - ADDR_W - BYTE_PAGE_W;

  logic [ADDR_W:0] units;
  assign units = {1'b0, cnt_i} + 1'b1;

  if (WORD_CH) begin : g_word
    logic unused_page_lsb;
    assign unused_page_lsb = page_i[0];
    assign bus_addr_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
    assign remain_o   = {units, 1'b0};
  end else begin : g_byte
    logic unused_page_hi;
    assign unused_page_hi = ^page_i[PAGE_W-1:BYTE_PAGE_W];
    assign bus_addr_o = {{PAD_W{1'b0}}, page_i[BYTE_PAGE_W-1:0], addr_i};
    assign remain_o   = {1'b0, units};
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_eng_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xfer_mode_t mode_i,
  input  logic       load_i,
  input  logic       xfer_i,
  input  logic       mask_set_i,
  input  logic       mask_clr_i,
  input  logic       cnt_zero_i,
  output logic       masked_o,
  output logic       tc_o,
  output logic       step_o,
  output logic       reload_o
);
  logic masked_q;
  logic go;
  logic stop;

  assign go       = xfer_i & ~masked_q & ~load_i;
  assign tc_o     = go & cnt_zero_i;
  assign stop     = tc_o & ~mode_i.auto_init;
  assign reload_o = load_i | (tc_o & mode_i.auto_init);
  assign step_o   = go & ~(cnt_zero_i & mode_i.auto_init);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 masked_q <= 1'b1;
    else if (mask_set_i || stop) masked_q <= 1'b1;
    else if (mask_clr_i)         masked_q <= 1'b0;
  end

  assign masked_o = masked_q;
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int BYTE_PAGE_W = 4,
  parameter bit WORD_CH     = 1'b0,
  localparam int BUS_W      = PAGE_W + ADDR_W,
  localparam int REM_W      = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] base_count_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              auto_init_i,
  input  logic              decrement_i,
  input  logic              load_i,
  input  logic              xfer_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  output logic [BUS_W-1:0]  bus_addr_o,
  output logic              tc_o,
  output logic              masked_o,
  output logic [ADDR_W-1:0] cur_count_o,
  output logic [REM_W-1:0]  remain_o
);
  xfer_mode_t        mode;
  logic              step;
  logic              reload;
  logic              cnt_zero;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] cur_cnt;

  assign mode.auto_init = auto_init_i;
  assign mode.down      = decrement_i;

  dma_chan_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .load_i     (load_i),
    .xfer_i     (xfer_i),
    .mask_set_i (mask_set_i),
    .mask_clr_i (mask_clr_i),
    .cnt_zero_i (cnt_zero),
    .masked_o   (masked_o),
    .tc_o       (tc_o),
    .step_o     (step),
    .reload_o   (reload)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .step_i   (step),
    .down_i   (mode.down),
    .base_i   (base_addr_i),
    .addr_o   (cur_addr)
  );

  dma_len_ctr #(.ADDR_W(ADDR_W)) i_len (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .step_i   (step),
    .base_i   (base_count_i),
    .cnt_o    (cur_cnt),
    .zero_o   (cnt_zero)
  );

  dma_addr_map #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .BYTE_PAGE_W (BYTE_PAGE_W),
    .WORD_CH     (WORD_CH)
  ) i_map (
    .page_i     (page_i),
    .addr_i     (cur_addr),
    .cnt_i      (cur_cnt),
    .bus_addr_o (bus_addr_o),
    .remain_o   (remain_o)
  );

  assign cur_count_o = cur_cnt;
endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
  parameter int ADDR_W      = 16,
  parameter int BYTE_PAGE_W = 4,
  parameter int BUS_W       = 24,
  parameter bit WORD_CH     = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] base_count_i,
  input logic              auto_init_i,
  input logic              decrement_i,
  input logic              load_i,
  input logic              xfer_i,
  input logic [BUS_W-1:0]  bus_addr_o,
  input logic              tc_o,
  input logic              masked_o,
  input logic [ADDR_W-1:0] cur_count_o
);
  logic [ADDR_W-1:0] ctr_view;

  if (WORD_CH) begin : g_word
    assign ctr_view = bus_addr_o[ADDR_W:1];
    always_comb if (rst_ni) p_word_lsb_r4: assert (bus_addr_o[0] == 1'b0);
  end else begin : g_byte
    assign ctr_view = bus_addr_o[ADDR_W-1:0];
    always_comb if (rst_ni)
      p_byte_hi_zero_r3: assert (bus_addr_o[BUS_W-1:ADDR_W+BYTE_PAGE_W] == '0);
  end

  p_tc_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (!masked_o && cur_count_o == '0 && xfer_i));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_count_o == $past(base_count_i));

  p_stop_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !auto_init_i) |=> masked_o);

  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && auto_init_i) |=> cur_count_o == $past(base_count_i));

  p_masked_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o && !load_i) |=> $stable(cur_count_o));

  p_up_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !masked_o && !load_i && !tc_o && !decrement_i)
      |=> ctr_view == ADDR_W'($past(ctr_view) + 1'b1));

  p_down_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !masked_o && !load_i && !tc_o && decrement_i)
      |=> ctr_view == ADDR_W'($past(ctr_view) - 1'b1));
endmodule

bind dma_addr_engine dma_addr_engine_chk #(
  .ADDR_W      (ADDR_W),
  .BYTE_PAGE_W (BYTE_PAGE_W),
  .BUS_W       (BUS_W),
  .WORD_CH     (WORD_CH)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .base_count_i (base_count_i),
  .auto_init_i  (auto_init_i),
  .decrement_i  (decrement_i),
  .load_i       (load_i),
  .xfer_i       (xfer_i),
  .bus_addr_o   (bus_addr_o),
  .tc_o         (tc_o),
  .masked_o     (masked_o),
  .cur_count_o  (cur_count_o)
);

// File: tb/test_dma_addr_engine.sv
module test_dma_addr_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ba = '0, bc = '0;
  logic [7:0]  pg = '0;
  logic        au = 1'b0, dn = 1'b0, ld = 1'b0, xf = 1'b0, ms = 1'b0, mc = 1'b0;

  logic [23:0] bus_b, bus_w;
  logic        tc_b, tc_w, msk_b, msk_w;
  logic [15:0] cnt_b, cnt_w;
  logic [17:0] rem_b, rem_w;

  logic [15:0] m_a, m_c;
  logic        m_m;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_engine #(.WORD_CH(1'b0)) i_dma_addr_engine (
    .clk_i(clk), .rst_ni(rst_n), .base_addr_i(ba), .base_count_i(bc), .page_i(pg),
    .auto_init_i(au), .decrement_i(dn), .load_i(ld), .xfer_i(xf),
    .mask_set_i(ms), .mask_clr_i(mc), .bus_addr_o(bus_b), .tc_o(tc_b),
    .masked_o(msk_b), .cur_count_o(cnt_b), .remain_o(rem_b));

  dma_addr_engine #(.WORD_CH(1'b1)) i_dma_addr_engine_w (
    .clk_i(clk), .rst_ni(rst_n), .base_addr_i(ba), .base_count_i(bc), .page_i(pg),
    .auto_init_i(au), .decrement_i(dn), .load_i(ld), .xfer_i(xf),
    .mask_set_i(ms), .mask_clr_i(mc), .bus_addr_o(bus_w), .tc_o(tc_w),
    .masked_o(msk_w), .cur_count_o(cnt_w), .remain_o(rem_w));

  function automatic logic [31:0] exp_addr(input bit word, input logic [7:0] p,
                                           input logic [15:0] a);
    if (word) return {8'h0, p[7:1], a, 1'b0};
    return {8'h0, 4'h0, p[3:0], a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic x, input logic s, input logic c);
    logic e_tc, stop;
    ld = l; xf = x; ms = s; mc = c;
    #1;
    e_tc = x & ~l & ~m_m & (m_c == 16'h0);
    chk("R3 byte address", 32'(bus_b), exp_addr(1'b0, pg, m_a));
    chk("R4 word address", 32'(bus_w), exp_addr(1'b1, pg, m_a));
    chk("R7 tc byte", 32'(tc_b), 32'(e_tc));
    chk("R7 tc word", 32'(tc_w), 32'(e_tc));
    chk("R10 mask", 32'({msk_b, msk_w}), 32'({m_m, m_m}));
    chk("R7 count", 32'(cnt_b), 32'(m_c));
    chk("R7 count word", 32'(cnt_w), 32'(m_c));
    chk("R11 byte remain", 32'(rem_b), 32'(m_c) + 1);
    chk("R11 word remain", 32'(rem_w), (32'(m_c) + 1) * 2);
    @(posedge clk);
    stop = 1'b0;
    if (l) begin
      m_a = ba; m_c = bc;
    end else if (x && !m_m) begin
      if (m_c == 16'h0 && au) begin
        m_a = ba; m_c = bc;
      end else begin
        if (m_c == 16'h0) stop = 1'b1;
        m_a = dn ? m_a - 1'b1 : m_a + 1'b1;
        m_c = m_c - 1'b1;
      end
    end
    if (s || stop) m_m = 1'b1;
    else if (c)    m_m = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);
    m_a = '0; m_c = '0; m_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset mask", 32'(msk_b), 32'd1);
    chk("R1 reset count", 32'(cnt_b), 32'd0);
    chk("R1 reset address", 32'(bus_b), 32'd0);

    // R5 increment, wrap inside page, N=count+1 transfers, stop (R8)
    pg = 8'h35; ba = 16'hFFFE; bc = 16'd2; au = 1'b0; dn = 1'b0;
    step(1, 0, 0, 0);
    chk("R2 load count", 32'(cnt_b), 32'd2);
    chk("R2 load address", 32'(bus_b), 32'h05FFFE);
    step(0, 0, 0, 1);
    repeat (3) step(0, 1, 0, 0);
    chk("R5 wrap keeps page", 32'(bus_b), 32'h050001);
    chk("R4 word wrap keeps page", 32'(bus_w), 32'h340002);
    chk("R8 masked after stop", 32'(msk_b), 32'd1);
    chk("R8 count wrapped", 32'(cnt_b), 32'hFFFF);
    step(0, 1, 0, 0);
    chk("R8 strobe ignored", 32'(cnt_b), 32'hFFFF);

    // R6 decrement across zero
    dn = 1'b1; ba = 16'h0001; bc = 16'd3;
    step(1, 0, 0, 1);
    repeat (2) step(0, 1, 0, 0);
    chk("R6 decrement wrap", 32'(bus_b[15:0]), 32'hFFFF);

    // R9 auto-initialise
    dn = 1'b0; au = 1'b1; ba = 16'h0100; bc = 16'd1;
    step(1, 0, 0, 0);
    repeat (2) step(0, 1, 0, 0);
    chk("R9 reload count", 32'(cnt_b), 32'd1);
    chk("R9 reload address", 32'(bus_b[15:0]), 32'h0100);
    chk("R9 stays unmasked", 32'(msk_b), 32'd0);

    // R10 set wins over clear, strobe ignored while masked
    step(0, 1, 1, 1);
    chk("R10 set wins", 32'(msk_b), 32'd1);
    step(0, 1, 0, 0);
    chk("R10 masked strobe ignored", 32'(cnt_b), 32'd0);

    // R12 load beats transfer at count zero
    step(0, 0, 0, 1);
    ba = 16'h4242; bc = 16'h0010;
    step(1, 1, 0, 0);
    chk("R12 load priority count", 32'(cnt_b), 32'h0010);
    chk("R12 load priority addr", 32'(bus_b[15:0]), 32'h4242);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic l, x, s, c;
      r = $urandom;
      if (r[3:0] == 4'h0) begin
        ba = r[4] ? 16'(16'hFFFF - r[7:5]) : 16'($urandom);
        bc = r[8] ? 16'(r[11:9]) : 16'($urandom_range(0, 40));
        pg = 8'($urandom);
        au = r[12];
        dn = r[13];
      end
      l = ($urandom_range(0, 15) == 0);
      x = ($urandom_range(0, 3) != 0);
      s = ($urandom_range(0, 31) == 0);
      c = ($urandom_range(0, 7) == 0);
      step(l, x, s, c);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule